// File: doc/BRIEF.md
# Key-protected independent watchdog timer

The block is a watchdog down-counter that sits behind a small single-clock register bus. Software does not set control bits to drive it. It writes 16-bit key codes to one register instead. One code starts the watchdog, one refreshes it, and two more open and close write access to the configuration registers. Once the watchdog runs, no register write stops it. If software fails to refresh it in time, the block raises a one-cycle reset request and keeps counting from the reload value.

The counter steps once per prescale period, and the prescale period is a power of two of at least 4 input cycles. A new prescaler or reload value does not act at once. It sits in a holding register, and a status bit stays busy for a fixed number of cycles until the value is applied. An optional early warning raises a level interrupt when the count steps down onto a programmed compare value. The interrupt stays high until software acknowledges it.

Top module: `key_wdog`

## Requirements
- R1: The byte offsets are: key register 0x00, prescaler 0x04, reload 0x08, status 0x0C and early-warning register 0x14. The key register, offset 0x10 and every unmapped offset read as zero. Nothing is returned unless `req_i` is high and `we_i` is low.
- R2: After reset the watchdog is stopped. The counter holds 0xFFF, the prescaler code is 0, the reload value is 0xFFF, configuration is locked, the status reads 0, the early warning is disabled with compare value 0, and `irq_o` is low.
- R3: Writing 0xCCCC to bits 15:0 of the key register starts counting. After that, no write stops it, including the lock key 0x0000.
- R4: Writing 0xAAAA to the key register loads the counter with the applied reload value and restarts the prescale phase. This takes effect even while the watchdog is stopped.
- R5: Writing 0x5555 to the key register opens write access to 0x04, 0x08 and the compare and enable fields of 0x14. Writing 0x0000 closes it. Writes to those fields while access is closed change nothing.
- R6: Prescaler code c in bits 3:0 gives a step period of 4 << c cycles. Codes above 8 behave as 8, which gives 1024.
- R7: When a step finds the counter at 0, `rst_req_o` is high for exactly one cycle and the counter reloads. A start or refresh therefore leads to a pulse (reload+1)*ratio cycles later.
- R8: Status bit 0 (prescaler) and bit 1 (reload) go high for BUSY_CYC cycles after an accepted write. The value is applied when the bit falls. A new write during the busy time restarts the count.
- R9: In register 0x14, bits 11:0 hold the compare value and bit 15 is the enable. When enabled, a step that decrements the counter onto the compare value sets `irq_o`. `irq_o` stays high until a write with bit 14 set, which works while access is locked. A set and an acknowledge in the same cycle leave `irq_o` high.
- R10: Reading 0x04 or 0x08 returns the last accepted written value, including while its status bit is busy. Reading 0x14 returns the enable in bit 15 and the compare value in bits 11:0, with bit 14 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| irq_o | output | 1 | Early-warning interrupt level |

## Verification
The main function is tested in four ways. First, the watchdog runs free from its reset values, which shows the 0xFFF start count and the ratio of 4. Then it runs with a short reload and ratios of 4, 16 and a clamped 1024. Comparing the spacing of the pulses tells a correct ratio and clamp apart from an off-by-one step or a missing reload. A stream of refreshes arriving just before expiry must hold the pulse off. This tells a refresh that restarts the prescale phase apart from one that only reloads the count. Locked writes, writes during the busy time, and acknowledges that coincide with a warning show whether protection, delayed apply and set priority are kept apart.

// File: rtl/key_wdog_pkg.sv
package key_wdog_pkg;
  localparam logic [4:0] OFF_KEY = 5'h00;
  localparam logic [4:0] OFF_PRE = 5'h04;
  localparam logic [4:0] OFF_RLD = 5'h08;
  localparam logic [4:0] OFF_STS = 5'h0C;
  localparam logic [4:0] OFF_EWC = 5'h14;

  localparam logic [15:0] KEY_RUN  = 16'hCCCC;
  localparam logic [15:0] KEY_FEED = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN = 16'h5555;
  localparam logic [15:0] KEY_SHUT = 16'h0000;

  localparam int EWC_EN_BIT  = 15;
  localparam int EWC_ACK_BIT = 14;
endpackage

// File: rtl/key_wdog_stage.sv
module key_wdog_stage #(
  parameter int W        = 12,
  parameter int BUSY_CYC = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         busy_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= RST_VAL;
      active_o <= RST_VAL;
      cnt_q    <= '0;
    end else if (wr_i) begin
      shadow_o <= wdata_i;
      cnt_q    <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) active_o <= shadow_o;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(active_o));
endmodule

// File: rtl/key_wdog_core.sv
module key_wdog_core #(
  parameter int PRE_W   = 4,
  parameter int RLD_W   = 12,
  parameter int PRE_MAX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             feed_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [RLD_W-1:0] rld_i,
  input  logic [RLD_W-1:0] cmp_i,
  output logic             rst_req_o,
  output logic             warn_o
);
  localparam int PC_W = PRE_MAX + 2;
  localparam logic [PRE_W-1:0] CODE_TOP = PRE_W'(PRE_MAX);

  logic             run_q;
  logic [RLD_W-1:0] cnt_q;
  logic [PC_W-1:0]  pc_q;
  logic [PRE_W-1:0] code_c;
  logic [PC_W-1:0]  lim;
  logic             tick;

  always_comb begin
    code_c = (pre_code_i > CODE_TOP) ? CODE_TOP : pre_code_i;
    lim    = {PC_W{1'b1}} >> (CODE_TOP - code_c);
  end

  assign tick   = run_q && (pc_q >= lim);
  assign warn_o = tick && !feed_i && (cnt_q != '0) && ((cnt_q - 1'b1) == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '1;
      pc_q      <= '0;
      rst_req_o <= 1'b0;
    end else begin
      run_q     <= run_q | start_i;
      rst_req_o <= tick && !feed_i && (cnt_q == '0);
      if (feed_i) begin
        cnt_q <= rld_i;
        pc_q  <= '0;
      end else if (tick) begin
        pc_q  <= '0;
        cnt_q <= (cnt_q == '0) ? rld_i : cnt_q - 1'b1;
      end else if (run_q) begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  // R3
  run_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
  // R7
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R7
  pulse_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> run_q);
endmodule

// File: rtl/key_wdog_regs.sv
module key_wdog_regs
  import key_wdog_pkg::*;
#(
  parameter int PRE_W    = 4,
  parameter int RLD_W    = 12,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [4:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             warn_i,
  output logic             start_o,
  output logic             feed_o,
  output logic [PRE_W-1:0] pre_act_o,
  output logic [RLD_W-1:0] rld_act_o,
  output logic [RLD_W-1:0] cmp_o,
  output logic             irq_o
);
  logic             wr, key_wr, unlock_q, pre_wr, rld_wr, ewc_wr, ack;
  logic [15:0]      key;
  logic [PRE_W-1:0] pre_sh;
  logic [RLD_W-1:0] rld_sh;
  logic             pre_busy, rld_busy, ew_en_q;

  assign wr      = req_i && we_i;
  assign key     = wdata_i[15:0];
  assign key_wr  = wr && (addr_i == OFF_KEY);
  assign start_o = key_wr && (key == KEY_RUN);
  assign feed_o  = key_wr && (key == KEY_FEED);
  assign pre_wr  = wr && unlock_q && (addr_i == OFF_PRE);
  assign rld_wr  = wr && unlock_q && (addr_i == OFF_RLD);
  assign ewc_wr  = wr && unlock_q && (addr_i == OFF_EWC);
  assign ack     = wr && (addr_i == OFF_EWC) && wdata_i[EWC_ACK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      ew_en_q  <= 1'b0;
      cmp_o    <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (key_wr && key == KEY_OPEN) unlock_q <= 1'b1;
      else if (key_wr && key == KEY_SHUT) unlock_q <= 1'b0;
      if (ewc_wr) begin
        ew_en_q <= wdata_i[EWC_EN_BIT];
        cmp_o   <= wdata_i[RLD_W-1:0];
      end
      // a fresh warning outranks a same-cycle acknowledge
      irq_o <= (warn_i && ew_en_q) || (irq_o && !ack);
    end
  end

  key_wdog_stage #(.W(PRE_W), .BUSY_CYC(BUSY_CYC), .RST_VAL('0)) u_pre (
    .clk_i, .rst_ni, .wr_i(pre_wr), .wdata_i(wdata_i[PRE_W-1:0]),
    .shadow_o(pre_sh), .active_o(pre_act_o), .busy_o(pre_busy));

  key_wdog_stage #(.W(RLD_W), .BUSY_CYC(BUSY_CYC), .RST_VAL('1)) u_rld (
    .clk_i, .rst_ni, .wr_i(rld_wr), .wdata_i(wdata_i[RLD_W-1:0]),
    .shadow_o(rld_sh), .active_o(rld_act_o), .busy_o(rld_busy));

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_PRE: rdata_o[PRE_W-1:0] = pre_sh;
        OFF_RLD: rdata_o[RLD_W-1:0] = rld_sh;
        OFF_STS: rdata_o[1:0]       = {rld_busy, pre_busy};
        OFF_EWC: begin
          rdata_o[EWC_EN_BIT]  = ew_en_q;
          rdata_o[RLD_W-1:0]   = cmp_o;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  // R5
  locked_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !unlock_q && addr_i == OFF_PRE) |=> $stable(pre_sh));
  // R5
  locked_rld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !unlock_q && addr_i == OFF_RLD) |=> $stable(rld_sh));
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack) |=> irq_o);
endmodule

// File: rtl/key_wdog.sv
module key_wdog #(
  parameter int PRE_W    = 4,
  parameter int RLD_W    = 12,
  parameter int PRE_MAX  = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rst_req_o,
  output logic        irq_o
);
  logic             start, feed, warn;
  logic [PRE_W-1:0] pre_act;
  logic [RLD_W-1:0] rld_act, cmp;

  key_wdog_regs #(.PRE_W(PRE_W), .RLD_W(RLD_W), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .warn_i(warn), .start_o(start), .feed_o(feed),
    .pre_act_o(pre_act), .rld_act_o(rld_act), .cmp_o(cmp), .irq_o);

  key_wdog_core #(.PRE_W(PRE_W), .RLD_W(RLD_W), .PRE_MAX(PRE_MAX)) u_core (
    .clk_i, .rst_ni, .start_i(start), .feed_i(feed),
    .pre_code_i(pre_act), .rld_i(rld_act), .cmp_i(cmp),
    .rst_req_o, .warn_o(warn));
endmodule

// File: tb/key_wdog_bench.sv
module key_wdog_bench;
  localparam int CLK_P = 10;
  localparam int BUSY  = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int vec = 0, bad = 0, cyc = 0;
  string ph = "R2";

  // reference state
  int m_run, m_cnt, m_pc, m_pa, m_ps, m_ra, m_rs, m_pb, m_rb, m_unl, m_en, m_cmp, m_irq, m_rst;

  key_wdog u_key_wdog (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;

  function automatic int m_read(input int a);
    case (a)
      4:  return m_ps;
      8:  return m_rs;
      12: return ((m_rb > 0) ? 2 : 0) | ((m_pb > 0) ? 1 : 0);
      20: return (m_en << 15) | m_cmp;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_run = 0; m_cnt = 4095; m_pc = 0; m_pa = 0; m_ps = 0; m_ra = 4095; m_rs = 4095;
    m_pb = 0; m_rb = 0; m_unl = 0; m_en = 0; m_cmp = 0; m_irq = 0; m_rst = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int ratio, key, warn, wr, ack;
      ratio = 4 << ((m_pa > 8) ? 8 : m_pa);
      wr  = req && we;
      key = wdata[15:0];
      warn = 0; m_rst = 0;
      ack = wr && addr == 20 && wdata[14];
      if (wr && addr == 0 && key == 'hAAAA) begin m_cnt = m_ra; m_pc = 0; end
      else if (m_run) begin
        if (m_pc >= ratio - 1) begin
          m_pc = 0;
          if (m_cnt == 0) begin m_rst = 1; m_cnt = m_ra; end
          else begin m_cnt--; warn = (m_cnt == m_cmp); end
        end else m_pc++;
      end
      m_irq = (warn && m_en) || (m_irq && !ack);
      if (wr && addr == 0 && key == 'hCCCC) m_run = 1;
      if (wr && addr == 4 && m_unl) begin m_ps = wdata[3:0]; m_pb = BUSY; end
      else if (m_pb > 0) begin m_pb--; if (m_pb == 0) m_pa = m_ps; end
      if (wr && addr == 8 && m_unl) begin m_rs = wdata[11:0]; m_rb = BUSY; end
      else if (m_rb > 0) begin m_rb--; if (m_rb == 0) m_ra = m_rs; end
      if (wr && addr == 20 && m_unl) begin m_en = wdata[15]; m_cmp = wdata[11:0]; end
      if (wr && addr == 0 && key == 'h5555) m_unl = 1;
      else if (wr && addr == 0 && key == 'h0000) m_unl = 0;
    end
  end

  // per-cycle output comparison
  always @(negedge clk) if (rst_n) begin
    vec++;
    if (rst_req !== m_rst[0]) begin
      bad++; $display("FAIL R7 (%s) cyc %0d rst_req_o=%0b exp %0b", ph, cyc, rst_req, m_rst[0]);
    end
    vec++;
    if (irq !== m_irq[0]) begin
      bad++; $display("FAIL R9 (%s) cyc %0d irq_o=%0b exp %0b", ph, cyc, irq, m_irq[0]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); req = 1; we = 1; addr = a[4:0]; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_reg(input int a, input string tag);
    int e;
    @(negedge clk); req = 1; we = 0; addr = a[4:0];
    #1; e = m_read(a); vec++;
    if (rdata !== e[31:0]) begin
      bad++; $display("FAIL %s (%s) read 0x%0h = 0x%0h exp 0x%0h", tag, ph, a, rdata, e);
    end
    @(negedge clk); req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3); rst_n = 1;
    // R2 R1 reset values and zero-read offsets
    ph = "R2";
    rd_reg(4, "R2"); rd_reg(8, "R2"); rd_reg(12, "R2"); rd_reg(20, "R2");
    rd_reg(0, "R1"); rd_reg(16, "R1"); rd_reg(28, "R1");
    // R5 locked writes ignored
    ph = "R5";
    wr_reg(4, 3); wr_reg(8, 7); wr_reg(20, 'h8005);
    rd_reg(4, "R5"); rd_reg(8, "R5"); rd_reg(20, "R5"); rd_reg(12, "R5");
    // R3 R2 free run from 0xFFF at ratio 4
    ph = "R3";
    wr_reg(0, 'hCCCC);
    idle(16500);
    // R8 R10 unlock, program, observe busy window
    ph = "R8";
    wr_reg(0, 'h5555);
    wr_reg(8, 5); rd_reg(12, "R8"); rd_reg(8, "R10"); rd_reg(12, "R8");
    wr_reg(4, 0); wr_reg(4, 0); rd_reg(12, "R8"); idle(6); rd_reg(12, "R8");
    // R4 R7 refresh then let expire twice
    ph = "R4";
    wr_reg(0, 'hAAAA); idle(60);
    // R4 refreshes just before expiry hold pulse off
    for (int i = 0; i < 6; i++) begin idle(18); wr_reg(0, 'hAAAA); end
    // R3 lock key does not stop it
    ph = "R3";
    wr_reg(0, 'h0000); idle(60);
    wr_reg(4, 2); rd_reg(4, "R5");
    // R6 ratio 16, then clamped code 12
    ph = "R6";
    wr_reg(0, 'h5555); wr_reg(4, 2); idle(8); wr_reg(0, 'hAAAA); idle(200);
    wr_reg(8, 2); wr_reg(4, 12); idle(8); rd_reg(4, "R10"); wr_reg(0, 'hAAAA); idle(7000);
    // R8 rewrite restarts busy
    ph = "R8";
    wr_reg(4, 0); idle(2); wr_reg(4, 1); idle(1); rd_reg(12, "R8"); idle(6); rd_reg(12, "R8");
    wr_reg(4, 0); wr_reg(8, 9); idle(8); wr_reg(0, 'hAAAA);
    // R9 early warning, hold, locked ack
    ph = "R9";
    wr_reg(20, 'h8004); rd_reg(20, "R10"); idle(40);
    wr_reg(0, 'h0000); wr_reg(20, 'h0003); rd_reg(20, "R5");
    wr_reg(20, 'h4000); idle(50);
    for (int i = 0; i < 40; i++) wr_reg(20, 'h4000);
    wr_reg(0, 'h5555); wr_reg(20, 'h0004); idle(60);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule